// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit settles control flow for a single-instruction conditional branch that compares two register values directly. No flags register sits between the compare and the branch. In each cycle it accepts the current program counter, two operand values, a three-bit condition selector and a signed offset. It also accepts two strobes: one for a conditional branch, and one for a register-indirect jump that carries a base register value. One clock edge later it presents a redirect flag and the address to fetch next.

A conditional branch resolves against one of six signed relations, or against an always or never code. The relation is taken between source A and either source B or zero, depending on a mode input. When the branch is taken, the target is the branch's own address plus the sign-extended byte offset. A register-indirect jump always redirects, to the base value plus the same offset. Every other case falls through to the program counter plus four. All targets are word aligned by clearing the two low bits.

Top module: `cbr_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registered outputs become `taken_o`=0 and `npc_o`=`RESET_PC` (default 0).
- R2: Outputs are registered. Inputs captured at one rising edge appear at the outputs after that edge, and stay unchanged until the next edge.
- R3: With `br_valid_i`=1, the `cond_i` codes 0 to 5 select, in turn, signed less-than, greater-than, greater-or-equal, less-or-equal, equal and not-equal of source A against the compare operand. `taken_o` is 1 exactly when the relation holds.
- R4: `cond_i`=6 makes a valid branch always taken. `cond_i`=7 makes it never taken.
- R5: A taken conditional branch sets `npc_o` to (`pc_i` + sign-extended `offset_i`) with bits [1:0] forced to 0.
- R6: When no strobe is high, or a valid branch is not taken, `taken_o`=0 and `npc_o` is (`pc_i`+4, wrapping modulo 2^AW) with bits [1:0] forced to 0.
- R7: `jr_valid_i`=1 gives `taken_o`=1 and `npc_o` = (`base_i` + sign-extended `offset_i`) with bits [1:0] cleared. It overrides `br_valid_i` and `cond_i`.
- R8: When `zero_cmp_i`=1, the compare operand is zero instead of `src_b_i`, and `src_b_i` has no effect on the decision.
- R9: Bits [1:0] of `npc_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid_i | input | 1 | Conditional branch present this cycle |
| jr_valid_i | input | 1 | Register-indirect jump present this cycle |
| cond_i | input | 3 | Condition code (0 LT, 1 GT, 2 GE, 3 LE, 4 EQ, 5 NE, 6 always, 7 never) |
| zero_cmp_i | input | 1 | Compare source A against zero |
| pc_i | input | AW | Address of the branch instruction |
| src_a_i | input | DW | First compare operand |
| src_b_i | input | DW | Second compare operand |
| base_i | input | AW | Base register value for the indirect jump |
| offset_i | input | OW | Signed byte offset from the instruction |
| taken_o | output | 1 | Flow is redirected |
| npc_o | output | AW | Next program counter |

## Verification
A wrong compare decision shows on `taken_o` one edge after the branch is presented. When the decision is wrong, `npc_o` carries the fall-through address in place of the target, or the reverse, in that same cycle. Two kinds of fault therefore surface within one cycle of the stimulus that exposes them. A sign-handling fault shows when operands straddle the sign boundary. A priority fault shows when both strobes are high. Because the design holds no state other than the output register, no error carries forward. A reset fault is visible in the cycle after reset is applied.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
   typedef enum logic [2:0] {
      CC_LT  = 3'd0,
      CC_GT  = 3'd1,
      CC_GE  = 3'd2,
      CC_LE  = 3'd3,
      CC_EQ  = 3'd4,
      CC_NE  = 3'd5,
      CC_ALW = 3'd6,
      CC_NEV = 3'd7
   } cbr_cond_e;
endpackage

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
   import cbr_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          zero_cmp_i,
   input  logic [2:0]    cond_i,
   output logic          hit_o
);
   logic [DW-1:0] rhs;
   logic          lt_s;
   logic          eq;
   cbr_cond_e     cc;

   assign rhs  = zero_cmp_i ? '0 : b_i;
   assign lt_s = $signed(a_i) < $signed(rhs);
   assign eq   = (a_i == rhs);
   assign cc   = cbr_cond_e'(cond_i);

   always_comb begin
      unique case (cc)
         CC_LT:   hit_o = lt_s;
         CC_GT:   hit_o = !lt_s && !eq;
         CC_GE:   hit_o = !lt_s;
         CC_LE:   hit_o = lt_s || eq;
         CC_EQ:   hit_o = eq;
         CC_NE:   hit_o = !eq;
         CC_ALW:  hit_o = 1'b1;
         default: hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
   parameter int AW = 32,
   parameter int OW = 16
) (
   input  logic [AW-1:0] base_i,
   input  logic [OW-1:0] off_i,
   output logic [AW-1:0] tgt_o
);
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
   logic [AW-1:0] off_ext;
   logic [AW-1:0] sum;

   generate
      if (OW == AW) begin : g_full_off
         assign off_ext = off_i;
      end else begin : g_sext_off
         assign off_ext = {{(AW-OW){off_i[OW-1]}}, off_i};
      end
   endgenerate

   assign sum   = base_i + off_ext;
   assign tgt_o = sum & ALIGN_MASK;
endmodule

// File: rtl/cbr_unit.sv
module cbr_unit #(
   parameter int          AW       = 32,
   parameter int          DW       = 32,
   parameter int          OW       = 16,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          br_valid_i,
   input  logic          jr_valid_i,
   input  logic [2:0]    cond_i,
   input  logic          zero_cmp_i,
   input  logic [AW-1:0] pc_i,
   input  logic [DW-1:0] src_a_i,
   input  logic [DW-1:0] src_b_i,
   input  logic [AW-1:0] base_i,
   input  logic [OW-1:0] offset_i,
   output logic          taken_o,
   output logic [AW-1:0] npc_o
);
   localparam logic [AW-1:0] STEP       = AW'(4);
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

   generate
      if (AW < 3) begin : g_bad_aw
         $error("cbr_unit: AW must be at least 3");
      end
      if (DW < 2) begin : g_bad_dw
         $error("cbr_unit: DW must be at least 2");
      end
      if (OW < 2 || OW > AW) begin : g_bad_ow
         $error("cbr_unit: OW must lie in 2..AW");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_rst
         $error("cbr_unit: RESET_PC must be word aligned");
      end
   endgenerate

   logic          cmp_hit;
   logic [AW-1:0] rel_tgt;
   logic [AW-1:0] ind_tgt;
   logic [AW-1:0] seq_pc;
   logic          take_d;
   logic [AW-1:0] nxt_d;
   logic          taken_q;
   logic [AW-1:0] npc_q;

   cbr_cond_eval #(.DW(DW)) u_cmp (
      .a_i        (src_a_i),
      .b_i        (src_b_i),
      .zero_cmp_i (zero_cmp_i),
      .cond_i     (cond_i),
      .hit_o      (cmp_hit)
   );

   cbr_target_gen #(.AW(AW), .OW(OW)) u_rel_tgt (
      .base_i (pc_i),
      .off_i  (offset_i),
      .tgt_o  (rel_tgt)
   );

   cbr_target_gen #(.AW(AW), .OW(OW)) u_ind_tgt (
      .base_i (base_i),
      .off_i  (offset_i),
      .tgt_o  (ind_tgt)
   );

   assign seq_pc = (pc_i + STEP) & ALIGN_MASK;

   always_comb begin
      if (jr_valid_i) begin
         take_d = 1'b1;
         nxt_d  = ind_tgt;
      end else if (br_valid_i && cmp_hit) begin
         take_d = 1'b1;
         nxt_d  = rel_tgt;
      end else begin
         take_d = 1'b0;
         nxt_d  = seq_pc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         npc_q   <= RESET_PC;
      end else begin
         taken_q <= take_d;
         npc_q   <= nxt_d;
      end
   end

   assign taken_o = taken_q;
   assign npc_o   = npc_q;
endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int OW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          br_valid_i,
   input logic          jr_valid_i,
   input logic [2:0]    cond_i,
   input logic          zero_cmp_i,
   input logic [AW-1:0] pc_i,
   input logic [DW-1:0] src_a_i,
   input logic [DW-1:0] src_b_i,
   input logic [AW-1:0] base_i,
   input logic [OW-1:0] offset_i,
   input logic          taken_o,
   input logic [AW-1:0] npc_o
);
   localparam logic [AW-1:0] MSK = ~AW'(3);

   AST_NPC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      npc_o[1:0] == 2'b00); // R9

   AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(br_valid_i) && !$past(jr_valid_i))
      |-> (!taken_o && npc_o == (($past(pc_i) + AW'(4)) & MSK))); // R6

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(jr_valid_i))
      |-> (taken_o && npc_o == (($past(base_i) + AW'($signed($past(offset_i)))) & MSK))); // R7

   AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(br_valid_i) && !$past(jr_valid_i) && taken_o)
      |-> (npc_o == (($past(pc_i) + AW'($signed($past(offset_i)))) & MSK))); // R5

   AST_EQ_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(br_valid_i) && !$past(jr_valid_i) && !$past(zero_cmp_i)
       && $past(cond_i) == 3'd4)
      |-> (taken_o == ($past(src_a_i) == $past(src_b_i)))); // R3

   AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(br_valid_i) && !$past(jr_valid_i) && $past(cond_i) == 3'd7)
      |-> !taken_o); // R4

   AST_ZERO_MODE_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(br_valid_i) && !$past(jr_valid_i) && $past(zero_cmp_i)
       && $past(cond_i) == 3'd4)
      |-> (taken_o == ($past(src_a_i) == '0))); // R8
endmodule

bind cbr_unit cbr_unit_chk #(.AW(AW), .DW(DW), .OW(OW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .br_valid_i (br_valid_i),
   .jr_valid_i (jr_valid_i),
   .cond_i     (cond_i),
   .zero_cmp_i (zero_cmp_i),
   .pc_i       (pc_i),
   .src_a_i    (src_a_i),
   .src_b_i    (src_b_i),
   .base_i     (base_i),
   .offset_i   (offset_i),
   .taken_o    (taken_o),
   .npc_o      (npc_o)
);

// File: tb/cbr_unit_tb.sv
module cbr_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int OW = 16;

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  cond;
      logic        zero;
      logic        br;
      logic        jr;
      logic [31:0] base;
      logic [15:0] off;
      logic        exp_t;
      logic [31:0] exp_npc;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VECS [NV] = '{
      // R3 signed LT
      '{32'h100, 32'hFFFF_FFFB, 32'h3, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'h3, 32'hFFFF_FFFB, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      // R3 GT
      '{32'h100, 32'h7, 32'h7, 3'd1, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      '{32'h100, 32'h8, 32'h7, 3'd1, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      // R3 GE
      '{32'h100, 32'h7, 32'h7, 3'd2, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'hFFFF_FFFF, 32'h0, 3'd2, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      // R3 LE
      '{32'h100, 32'h7, 32'h7, 3'd3, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'h7FFF_FFFF, 32'h8000_0000, 3'd3, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      // R3 EQ / NE
      '{32'h100, 32'h5, 32'h5, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'h5, 32'h6, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      '{32'h100, 32'h5, 32'h6, 3'd5, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'h5, 32'h5, 3'd5, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      // R4 always / never
      '{32'h100, 32'h1, 32'h2, 3'd6, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'h1, 32'h1, 3'd7, 1'b0, 1'b1, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      // R6 no strobe
      '{32'h100, 32'h1, 32'h2, 3'd6, 1'b0, 1'b0, 1'b0, 32'h0, 16'h20, 1'b0, 32'h104},
      // R5 negative offset, unaligned offset
      '{32'h100, 32'h0, 32'h0, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 16'hFFC0, 1'b1, 32'hC0},
      '{32'h100, 32'h0, 32'h0, 3'd6, 1'b0, 1'b1, 1'b0, 32'h0, 16'h23, 1'b1, 32'h120},
      // R7 indirect jump, overriding a never branch; negative offset with align
      '{32'h100, 32'h0, 32'h0, 3'd7, 1'b0, 1'b1, 1'b1, 32'h2000, 16'h64, 1'b1, 32'h2064},
      '{32'h100, 32'h0, 32'h0, 3'd0, 1'b0, 1'b0, 1'b1, 32'h2003, 16'hFFFC, 1'b1, 32'h1FFC},
      // R8 zero mode: src_b ignored
      '{32'h100, 32'h5, 32'h64, 3'd1, 1'b1, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 3'd0, 1'b1, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      '{32'h100, 32'h0, 32'h9, 3'd4, 1'b1, 1'b1, 1'b0, 32'h0, 16'h20, 1'b1, 32'h120},
      // R9 / R6 unaligned pc fall-through, wrap
      '{32'h102, 32'h0, 32'h0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0, 16'h0, 1'b0, 32'h104},
      '{32'hFFFF_FFFC, 32'h0, 32'h0, 3'd7, 1'b0, 1'b1, 1'b0, 32'h0, 16'h0, 1'b0, 32'h0},
      // R5 unaligned pc taken
      '{32'h106, 32'h2, 32'h1, 3'd1, 1'b0, 1'b1, 1'b0, 32'h0, 16'h10, 1'b1, 32'h114}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          br_valid_i = 1'b0;
   logic          jr_valid_i = 1'b0;
   logic [2:0]    cond_i = 3'd0;
   logic          zero_cmp_i = 1'b0;
   logic [AW-1:0] pc_i = '0;
   logic [DW-1:0] src_a_i = '0;
   logic [DW-1:0] src_b_i = '0;
   logic [AW-1:0] base_i = '0;
   logic [OW-1:0] offset_i = '0;
   logic          taken_o;
   logic [AW-1:0] npc_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cbr_unit #(.AW(AW), .DW(DW), .OW(OW)) dut_i (
      .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .jr_valid_i(jr_valid_i),
      .cond_i(cond_i), .zero_cmp_i(zero_cmp_i), .pc_i(pc_i), .src_a_i(src_a_i),
      .src_b_i(src_b_i), .base_i(base_i), .offset_i(offset_i),
      .taken_o(taken_o), .npc_o(npc_o)
   );

   task automatic check(input string req, input logic t_exp, input logic [AW-1:0] n_exp);
      checks++;
      if (taken_o !== t_exp || npc_o !== n_exp) begin
         fails++;
         $display("FAIL %s: taken=%0b npc=%h expected taken=%0b npc=%h",
                  req, taken_o, npc_o, t_exp, n_exp);
      end
   endtask

   task automatic drive(input vec_t v);
      pc_i = v.pc; src_a_i = v.a; src_b_i = v.b; cond_i = v.cond;
      zero_cmp_i = v.zero; br_valid_i = v.br; jr_valid_i = v.jr;
      base_i = v.base; offset_i = v.off;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", 1'b0, 32'h0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         if (i > 0) begin
            #1;
            check("R2 hold until edge", VECS[i-1].exp_t, VECS[i-1].exp_npc);
         end
         @(negedge clk);
         check($sformatf("vector %0d (R3..R9)", i), VECS[i].exp_t, VECS[i].exp_npc);
      end
      // R1 mid-run reset after a taken branch
      drive(VECS[12]);
      @(negedge clk);
      check("R4 always before reset", 1'b1, 32'h120);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", 1'b0, 32'h0);
      rst_n = 1'b1;
      // R8 same src_a, differing src_b in zero mode give same result
      drive('{32'h200, 32'hFFFF_FFF0, 32'hFFFF_FF00, 3'd0, 1'b1, 1'b1, 1'b0, 32'h0, 16'h8, 1'b1, 32'h208});
      @(negedge clk);
      check("R8 zero mode b=-256", 1'b1, 32'h208);
      src_b_i = 32'h7FFF_FFFF;
      @(negedge clk);
      check("R8 zero mode b=max", 1'b1, 32'h208);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule